// File: doc/BRIEF.md
# Paged Memory Window Controller

This block lets an 8-bit processor with a 16-bit address bus reach a 512 KB memory through a 16 KB window. The window occupies CPU addresses $8000 to $BFFF. A 5-bit bank number chooses which 16 KB slice of the large memory appears there. The processor sets the bank number by writing to any address in page $DE. Every one of the 256 addresses in that page reaches the same register. The register cannot be read back, and the block has no data-bus output.

The block works in a fast system clock domain. It samples the processor's phase-2 clock, read/write strobe, address and data. A write to page $DE is qualified by phase-2 being high. The data is held from the last system clock of the phase-2 high time. The bank register loads it on the first system clock edge after phase-2 falls, which is the end of the bus cycle.

Each cycle the block forms a 19-bit physical address from the bank number and CPU address bits 13:0. It raises a select for the banked memory during phase-2 of window accesses. For every address outside the window it raises a flag, so that other decoders can claim the access.

Top module: `bank_window_ctrl`

## Requirements
- R1: After a synchronous active-low reset the bank number is 0, so `mem_addr[18:14]` reads 0.
- R2: A bus cycle with `cpu_rw_n` = 0, `cpu_addr[15:8]` = 8'hDE and `cpu_phi2` high loads the bank number. The load happens on the first `clk` rising edge at which `cpu_phi2` is sampled low after being sampled high. Until that edge the old value stays visible.
- R3: The low address byte plays no part in the register decode: writes to $DE00, $DE7F, $DEFF and any other $DExx all load the bank.
- R4: Only `cpu_data[4:0]` is stored. Data bits 7:5 are discarded.
- R5: A read cycle (`cpu_rw_n` = 1) of any $DExx address leaves the bank number unchanged.
- R6: A write to any page other than $DE leaves the bank number unchanged.
- R7: `mem_addr` equals the bank number in bits 18:14 and `cpu_addr[13:0]` in bits 13:0.
- R8: `mem_sel` is 1 only while `cpu_phi2` is high and `cpu_addr[15:14]` = 2'b10 ($8000 to $BFFF). Otherwise it is 0.
- R9: `outside_win` is 1 exactly when `cpu_addr` lies outside $8000 to $BFFF, whatever the level of phase-2. It is never 1 together with `mem_sel`.
- R10: Without a qualifying phase-2 high-then-low sequence the bank number holds. This includes a write strobe to $DExx while phase-2 stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than phase-2 |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (observed only, never driven) |
| cpu_rw_n | input | 1 | CPU read/write strobe, 0 = write |
| cpu_phi2 | input | 1 | CPU phase-2 clock, already synchronous to `clk` |
| mem_addr | output | 19 | Physical address into the banked memory |
| mem_sel | output | 1 | Banked memory select, high active |
| outside_win | output | 1 | Access lies outside the window |

## Verification
On every cycle the embedded assertions check four things. The bank number changes only on a load pulse. A load pulse lasts a single clock and follows a sampled phase-2 high. The select never rises without phase-2 high inside the window, and the select and the outside flag are never high together. Whether a load carries the right value can be shown only by the bench's directed bus cycles. So can the moment the new bank becomes visible, the mirroring across the whole page, and the masking of bits 7:5. The same holds for ignoring reads, foreign pages and writes without phase-2, and for the 19-bit address formed at the edges of the window.

// File: rtl/bank_win_pkg.sv
// Package: shared sizes for the paged memory window controller.
// Assumes: a 16-bit CPU address, an 8-bit data bus and a window aligned
// to its own size.
package bank_win_pkg;
    localparam int CPU_ADDR_W = 16;
    localparam int CPU_DATA_W = 8;
    localparam int BANK_BITS  = 5;
    localparam int WIN_BITS   = 14;
    localparam int PHYS_W     = BANK_BITS + WIN_BITS;
    localparam int PAGE_BITS  = 8;
    localparam int SEL_BITS   = CPU_ADDR_W - WIN_BITS;

    typedef logic [BANK_BITS-1:0] bank_t;
endpackage

// File: rtl/bank_bus_decode.sv
// Module: bank_bus_decode
// Watches CPU bus cycles and produces a one-clock load pulse for the bank
// register at the end of a write cycle to the register page.
// Assumes: cpu_phi2 is synchronous to clk and stays high for at least one
// clk period. The page compare uses only the high address byte, so the
// register appears at every address in its page.
module bank_bus_decode #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 5,
    parameter int PAGE_W   = 8,
    parameter logic [PAGE_W-1:0] REG_PAGE = 8'hDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_rw_n,
    input  logic              cpu_phi2,
    output logic              load,
    output logic [BANK_W-1:0] load_val
);
    localparam int PAGE_LSB = ADDR_W - PAGE_W;

    logic              page_hit;
    logic              phi2_d;
    logic              wr_pend;
    logic [BANK_W-1:0] wr_val;

    // Address decode: the high byte only, the low byte is ignored
    always_comb page_hit = (cpu_addr[ADDR_W-1:PAGE_LSB] == REG_PAGE);

    // Track phase-2 and hold the write intent and data from the last high clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phi2_d  <= 1'b0;
            wr_pend <= 1'b0;
            wr_val  <= '0;
        end else begin
            phi2_d <= cpu_phi2;
            if (cpu_phi2) begin
                wr_pend <= page_hit & ~cpu_rw_n;
                wr_val  <= cpu_data[BANK_W-1:0];
            end
        end
    end

    // Phase-2 qualifies the strobe last: a load fires only on its falling edge
    always_comb begin
        load     = phi2_d & ~cpu_phi2 & wr_pend;
        load_val = wr_val;
    end

    // A load pulse cannot repeat on the next clock, since phase-2 must rise again
    assert_load_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    // A load follows a clock at which phase-2 was high
    assert_load_after_phi2_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> ($past(cpu_phi2) && !cpu_phi2));
endmodule

// File: rtl/bank_reg.sv
// Module: bank_reg
// The write-only bank number register. It loads on a decode pulse and
// clears to bank 0 on reset.
// Assumes: the load pulse is one clock wide and its value is stable with it.
module bank_reg #(
    parameter int BANK_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BANK_W-1:0] load_val,
    output logic [BANK_W-1:0] bank
);
    // Store a new bank number on a load pulse, bank 0 after reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank <= '0;
        else if (load)
            bank <= load_val;
    end

    // The bank number holds on every clock without a load pulse
    assert_bank_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bank));
endmodule

// File: rtl/bank_window_map.sv
// Module: bank_window_map
// Forms the physical address and the banked memory select from the bank
// number and the CPU address.
// Assumes: the window is aligned to its own size, so its base is matched
// on the address bits above the offset.
module bank_window_map #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 5,
    parameter int WIN_W  = 14,
    parameter logic [ADDR_W-WIN_W-1:0] WIN_TAG = 2'b10
) (
    input  logic                    cpu_phi2,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [BANK_W-1:0]       bank,
    output logic [BANK_W+WIN_W-1:0] mem_addr,
    output logic                    mem_sel,
    output logic                    outside_win
);
    localparam int TAG_W = ADDR_W - WIN_W;

    logic in_win;

    // Window match on the address bits above the offset
    always_comb in_win = (cpu_addr[ADDR_W-1:WIN_W] == WIN_TAG[TAG_W-1:0]);

    // Put the bank above the window offset and gate the select with phase-2
    always_comb begin
        mem_addr    = {bank, cpu_addr[WIN_W-1:0]};
        mem_sel     = in_win & cpu_phi2;
        outside_win = ~in_win;
    end
endmodule

// File: rtl/bank_window_ctrl.sv
// Module: bank_window_ctrl (top)
// Paged memory window controller. It decodes writes to the bank register
// page, holds the bank number and maps the CPU window into a 19-bit
// physical address.
// Assumes: the CPU inputs are synchronous to clk, and clk runs several
// times faster than phase-2. The block never drives the data bus.
module bank_window_ctrl
    import bank_win_pkg::*;
#(
    parameter logic [PAGE_BITS-1:0] REG_PAGE = 8'hDE,
    parameter logic [SEL_BITS-1:0]  WIN_TAG  = 2'b10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CPU_ADDR_W-1:0] cpu_addr,
    input  logic [CPU_DATA_W-1:0] cpu_data,
    input  logic                  cpu_rw_n,
    input  logic                  cpu_phi2,
    output logic [PHYS_W-1:0]     mem_addr,
    output logic                  mem_sel,
    output logic                  outside_win
);
    logic  load;
    bank_t load_val;
    bank_t bank;

    bank_bus_decode #(
        .ADDR_W  (CPU_ADDR_W),
        .DATA_W  (CPU_DATA_W),
        .BANK_W  (BANK_BITS),
        .PAGE_W  (PAGE_BITS),
        .REG_PAGE(REG_PAGE)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_addr(cpu_addr),
        .cpu_data(cpu_data),
        .cpu_rw_n(cpu_rw_n),
        .cpu_phi2(cpu_phi2),
        .load    (load),
        .load_val(load_val)
    );

    bank_reg #(
        .BANK_W(BANK_BITS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(load_val),
        .bank    (bank)
    );

    bank_window_map #(
        .ADDR_W (CPU_ADDR_W),
        .BANK_W (BANK_BITS),
        .WIN_W  (WIN_BITS),
        .WIN_TAG(WIN_TAG)
    ) u_map (
        .cpu_phi2   (cpu_phi2),
        .cpu_addr   (cpu_addr),
        .bank       (bank),
        .mem_addr   (mem_addr),
        .mem_sel    (mem_sel),
        .outside_win(outside_win)
    );

    // The select and the outside flag never claim the same access
    assert_sel_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_sel && outside_win));

    // At the ports, the select needs phase-2 high and an address inside the window
    assert_sel_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> (cpu_phi2 && cpu_addr[15:14] == WIN_TAG));
endmodule

// File: tb/tb_bank_window_ctrl.sv
// Directed bench for bank_window_ctrl. Each scenario task checks its own results.
module tb_bank_window_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rw_n = 1'b1;
    logic        cpu_phi2 = 1'b0;
    logic [18:0] mem_addr;
    logic        mem_sel;
    logic        outside_win;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    bank_window_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw_n(cpu_rw_n), .cpu_phi2(cpu_phi2), .mem_addr(mem_addr),
        .mem_sel(mem_sel), .outside_win(outside_win)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One full bus cycle: set-up, phase-2 high for three clocks, fall, one clock after
    task automatic bus_cycle(logic [15:0] a, logic [7:0] d, logic rw);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_rw_n = rw; cpu_phi2 = 1'b0;
        @(negedge clk); cpu_phi2 = 1'b1;
        repeat (3) @(negedge clk);
        cpu_phi2 = 1'b0;
        @(negedge clk);
        cpu_addr = 16'h0000; cpu_rw_n = 1'b1; cpu_data = 8'h00;
        @(negedge clk);
    endtask

    function automatic logic [4:0] bank_now();
        return mem_addr[18:14];
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bank after reset", bank_now(), 5'd0);
    endtask

    task automatic t_write_timing();
        logic [4:0] old_b = bank_now();
        @(negedge clk);
        cpu_addr = 16'hDE40; cpu_data = 8'h0B; cpu_rw_n = 1'b0;
        @(negedge clk); cpu_phi2 = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 old bank during phase-2", bank_now(), old_b);
        cpu_phi2 = 1'b0;
        #1 chk("R2 old bank before clock after fall", bank_now(), old_b);
        @(negedge clk);
        chk("R2 new bank one clock after fall", bank_now(), 5'h0B);
        cpu_rw_n = 1'b1; cpu_addr = 16'h0000;
        @(negedge clk);
    endtask

    task automatic t_mirror();
        logic [15:0] adrs [4] = '{16'hDE00, 16'hDE7F, 16'hDEFF, 16'hDE81};
        logic [4:0]  vals [4] = '{5'h11, 5'h1F, 5'h02, 5'h15};
        for (int i = 0; i < 4; i++) begin
            bus_cycle(adrs[i], {3'b000, vals[i]}, 1'b0);
            chk("R3 mirrored write loads bank", bank_now(), vals[i]);
        end
    endtask

    task automatic t_discard_high();
        bus_cycle(16'hDE10, 8'hE6, 1'b0);
        chk("R4 data bits 7:5 dropped", bank_now(), 5'h06);
        bus_cycle(16'hDE20, 8'hA0, 1'b0);
        chk("R4 data bits 7:5 dropped, low zero", bank_now(), 5'h00);
    endtask

    task automatic t_read_ignore();
        bus_cycle(16'hDE00, 8'h09, 1'b0);
        bus_cycle(16'hDE00, 8'h1C, 1'b1);
        chk("R5 read of DE00 ignored", bank_now(), 5'h09);
        bus_cycle(16'hDEFF, 8'h13, 1'b1);
        chk("R5 read of DEFF ignored", bank_now(), 5'h09);
    endtask

    task automatic t_other_page();
        bus_cycle(16'hDF00, 8'h1A, 1'b0);
        chk("R6 write to DF00 ignored", bank_now(), 5'h09);
        bus_cycle(16'hDD55, 8'h1A, 1'b0);
        chk("R6 write to DD55 ignored", bank_now(), 5'h09);
        bus_cycle(16'h9E00, 8'h1A, 1'b0);
        chk("R6 write to 9E00 ignored", bank_now(), 5'h09);
    endtask

    task automatic t_no_phi2();
        @(negedge clk);
        cpu_addr = 16'hDE00; cpu_data = 8'h1E; cpu_rw_n = 1'b0; cpu_phi2 = 1'b0;
        repeat (5) @(negedge clk);
        cpu_rw_n = 1'b1; cpu_addr = 16'h0000;
        @(negedge clk);
        chk("R10 write without phase-2 ignored", bank_now(), 5'h09);
    endtask

    task automatic t_map();
        logic [4:0]  banks [3] = '{5'h00, 5'h1F, 5'h0D};
        logic [13:0] offs  [3] = '{14'h0000, 14'h3FFF, 14'h2A5A};
        for (int b = 0; b < 3; b++) begin
            bus_cycle(16'hDE33, {3'b000, banks[b]}, 1'b0);
            for (int o = 0; o < 3; o++) begin
                @(negedge clk);
                cpu_addr = {2'b10, offs[o]}; cpu_rw_n = 1'b1; cpu_phi2 = 1'b1;
                #1 chk("R7 physical address", {13'd0, mem_addr}, {13'd0, banks[b], offs[o]});
                @(negedge clk); cpu_phi2 = 1'b0;
            end
        end
    endtask

    task automatic t_select();
        logic [15:0] adrs [8] = '{16'h7FFF, 16'h8000, 16'hA123, 16'hBFFF,
                                  16'hC000, 16'h0000, 16'hDE00, 16'hFFFF};
        for (int i = 0; i < 8; i++) begin
            logic inw = (adrs[i] >= 16'h8000) && (adrs[i] <= 16'hBFFF);
            @(negedge clk);
            cpu_addr = adrs[i]; cpu_rw_n = 1'b1; cpu_phi2 = 1'b0;
            #1;
            chk("R8 no select with phase-2 low", {31'd0, mem_sel}, 32'd0);
            chk("R9 outside flag, phase-2 low", {31'd0, outside_win}, {31'd0, !inw});
            @(negedge clk); cpu_phi2 = 1'b1;
            #1;
            chk("R8 select with phase-2 high", {31'd0, mem_sel}, {31'd0, inw});
            chk("R9 outside flag, phase-2 high", {31'd0, outside_win}, {31'd0, !inw});
            @(negedge clk); cpu_phi2 = 1'b0;
        end
    endtask

    initial begin
        t_reset();
        t_write_timing();
        t_mirror();
        t_discard_high();
        t_read_ignore();
        t_other_page();
        t_no_phi2();
        t_map();
        t_select();
        t_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule